// File: doc/BRIEF.md
# Analog Register Bus Command Master

This block gives a processor access to the 8-bit control registers held inside a group of on-chip analog slaves. Software places one 32-bit command word on the write port. The word names the slave, the register address, the direction and, for a write, the data byte. The block captures the word and raises a busy flag. It then sends the request over a bit-serial register bus. When the transfer finishes, busy drops. For a read, the fetched byte has by then replaced the data field of the same word, so one read-back returns both the completion status and the result.

A one-hot master-select vector is decoded from the slave identifier. It is rewritten as a whole on every accepted command, so no more than one select line is ever high. A command that arrives while busy is high is dropped. The serial engine runs at a bus clock derived from the system clock by a divider parameter. Behavioural register slaves are built in behind the select lines, so the block works as a closed unit. The bus clock, data and frame lines are also brought out as outputs so that the transfers can be observed.

Top module: `anreg_cmd_master`

## Requirements
- R1: The command word uses these bit positions: slave identifier in [7:0], register address in [15:8], data byte in [23:16], direction in [24], busy in [25]. Bits [31:26] read as zero. Reading back the word returns the captured identifier, address and direction.
- R2: An accepted command write raises busy (bit 25) in the next cycle. Busy stays high until the transfer is complete and then returns low.
- R3: Direction 1 writes the data byte into the addressed register of the selected slave. Direction 0 reads that register, and the byte appears in bits [23:16] once busy is low.
- R4: Slave identifiers select master-select lines as follows: 0x66 selects bit 5, 0x62 bit 6, 0x69 bit 7, 0x6F bit 8, 0x63 bit 9, 0x6D bit 10, 0x67 bit 11 and 0x6A bit 12. The selection is visible in the cycle after the command write.
- R5: Each accepted command replaces the whole select vector, so at most one select line is high at any time.
- R6: A command write received while busy is high has no effect. The fields in flight, the select vector and every slave register remain unchanged.
- R7: An identifier not listed in R4 drives all select lines low. A read to it completes with data 0x00, and a write to it changes no slave register.
- R8: Each transfer sends a 17-bit frame while the frame line is high. The frame holds the direction bit first, then the address MSB first, then the data byte MSB first. The bus clock stays low for DIV system cycles and high for DIV system cycles in each bit, and data is sampled on its rising edge.
- R9: Reset clears busy, the select vector, the whole command word (including the data field) and the frame line.
- R10: Each built-in slave decodes only the low log2(REG_DEPTH) address bits (the low 4 by default). All of its registers are cleared to 0x00 by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe, one cycle |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Command word read-back, with busy and returned data |
| sel_o | output | SEL_W (13) | One-hot master-select vector |
| bus_clk_o | output | 1 | Serial bus clock |
| bus_dat_o | output | 1 | Serial bus data from the master |
| bus_frame_o | output | 1 | High for the duration of a serial frame |

## Verification
The situation hardest to produce from the ports is a second command write that lands in the middle of a transfer. It only shows up in the results if the dropped command would have changed something: a different slave, the same address and a different value. The bench waits a fixed number of cycles after the first write so that the intruding strobe falls inside the serial frame. It then checks the read-back word and the select vector, and reads back the register that the dropped write targeted. Random traffic mixes listed and unlisted identifiers with full 8-bit addresses. This covers address aliasing in the slaves and reads from unlisted slaves returning zero.

// File: rtl/anreg_pkg.sv
package anreg_pkg;
   localparam int unsigned NUM_SLV = 8;
   localparam int unsigned ID_W    = 8;
   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned DAT_W   = 8;

   typedef struct packed {
      logic             dir;
      logic [DAT_W-1:0]  data;
      logic [ADDR_W-1:0] addr;
      logic [ID_W-1:0]   id;
   } cmd_t;

   localparam int unsigned CMD_W = $bits(cmd_t);

   // identifier owning select line (SEL_BASE + i)
   function automatic logic [ID_W-1:0] slv_id(input int unsigned i);
      case (i)
         0: slv_id = 8'h66;
         1: slv_id = 8'h62;
         2: slv_id = 8'h69;
         3: slv_id = 8'h6F;
         4: slv_id = 8'h63;
         5: slv_id = 8'h6D;
         6: slv_id = 8'h67;
         7: slv_id = 8'h6A;
         default: slv_id = '0;
      endcase
   endfunction
endpackage

// File: rtl/anreg_sel_decode.sv
module anreg_sel_decode
   import anreg_pkg::*;
#(
   parameter int unsigned SEL_W    = 13,
   parameter int unsigned SEL_BASE = 5
) (
   input  logic [ID_W-1:0]  id_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             hit_o
);
   logic [NUM_SLV-1:0] match;

   for (genvar i = 0; i < NUM_SLV; i++) begin : g_match
      assign match[i] = (id_i == slv_id(i));
   end

   always_comb begin
      sel_o = '0;
      sel_o[SEL_BASE +: NUM_SLV] = match;
   end

   assign hit_o = |match;

   always_comb begin
      assert_dec_onehot_R5: assert ($onehot0(match));
   end
endmodule

// File: rtl/anreg_shift_engine.sv
module anreg_shift_engine #(
   parameter int unsigned DIV    = 2,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DAT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DAT_W-1:0]  data_i,
   input  logic              din_i,
   output logic              bus_clk_o,
   output logic              bus_dat_o,
   output logic              frame_o,
   output logic              done_o,
   output logic [DAT_W-1:0]  rdata_o
);
   localparam int unsigned NBITS = 1 + ADDR_W + DAT_W;
   localparam int unsigned HDR   = 1 + ADDR_W;
   localparam int unsigned CNT_W = $clog2(NBITS);
   localparam int unsigned PH_W  = (DIV > 1) ? $clog2(DIV) : 1;

   logic [NBITS-1:0] tx_sr;
   logic [DAT_W-1:0] rx_sr;
   logic [CNT_W-1:0] bit_cnt;
   logic [PH_W-1:0]  ph_cnt;
   logic             sclk_q, frame_q, done_q, rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         bit_cnt <= '0;
         ph_cnt  <= '0;
         sclk_q  <= 1'b0;
         frame_q <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !frame_q) begin
            tx_sr   <= {dir_i, addr_i, data_i};
            rx_sr   <= '0;
            bit_cnt <= '0;
            ph_cnt  <= '0;
            sclk_q  <= 1'b0;
            frame_q <= 1'b1;
            rd_q    <= !dir_i;
         end else if (frame_q) begin
            if (ph_cnt == PH_W'(DIV - 1)) begin
               ph_cnt <= '0;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  if (rd_q && bit_cnt >= CNT_W'(HDR))
                     rx_sr <= {rx_sr[DAT_W-2:0], din_i};
               end else begin
                  sclk_q <= 1'b0;
                  tx_sr  <= {tx_sr[NBITS-2:0], 1'b0};
                  if (bit_cnt == CNT_W'(NBITS - 1)) begin
                     frame_q <= 1'b0;
                     done_q  <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end else begin
               ph_cnt <= ph_cnt + 1'b1;
            end
         end
      end
   end

   assign bus_clk_o = sclk_q;
   assign bus_dat_o = frame_q & tx_sr[NBITS-1];
   assign frame_o   = frame_q;
   assign done_o    = done_q;
   assign rdata_o   = rx_sr;

   assert_clk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_q |-> !sclk_q);
   assert_start_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !frame_q) |=> frame_q);
   assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !frame_q);
endmodule

// File: rtl/anreg_model_slave.sv
module anreg_model_slave #(
   parameter int unsigned REG_DEPTH = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DAT_W     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic frame_i,
   input  logic bus_clk_i,
   input  logic bus_dat_i,
   output logic miso_o
);
   localparam int unsigned NBITS = 1 + ADDR_W + DAT_W;
   localparam int unsigned HDR   = 1 + ADDR_W;
   localparam int unsigned CNT_W = $clog2(NBITS + 1);
   localparam int unsigned IDX_W = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;

   logic [DAT_W-1:0]  mem_q [REG_DEPTH];
   logic [NBITS-1:0]  sr;
   logic [CNT_W-1:0]  cnt;
   logic [DAT_W-1:0]  out_sr;
   logic [IDX_W-1:0]  idx_q;
   logic              wr_q, clk_q;
   logic              active, rise, fall;
   logic [ADDR_W-1:0] addr_now;
   logic [IDX_W-1:0]  idx_now;

   assign active   = sel_i && frame_i;
   assign rise     = active && bus_clk_i && !clk_q;
   assign fall     = active && !bus_clk_i && clk_q;
   assign addr_now = {sr[ADDR_W-2:0], bus_dat_i};
   assign idx_now  = addr_now[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_DEPTH; i++) mem_q[i] <= '0;
         sr     <= '0;
         cnt    <= '0;
         out_sr <= '0;
         idx_q  <= '0;
         wr_q   <= 1'b0;
         clk_q  <= 1'b0;
      end else begin
         clk_q <= bus_clk_i;
         if (!active) begin
            cnt <= '0;
         end else if (rise) begin
            sr  <= {sr[NBITS-2:0], bus_dat_i};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR - 1)) begin
               wr_q  <= sr[ADDR_W-1];
               idx_q <= idx_now;
               if (!sr[ADDR_W-1]) out_sr <= mem_q[idx_now];
            end
            if (cnt == CNT_W'(NBITS - 1) && wr_q)
               mem_q[idx_q] <= {sr[DAT_W-2:0], bus_dat_i};
         end else if (fall && cnt >= CNT_W'(HDR + 1)) begin
            out_sr <= {out_sr[DAT_W-2:0], 1'b0};
         end
      end
   end

   assign miso_o = sel_i & out_sr[DAT_W-1];

   assert_slave_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));
   assert_slave_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= CNT_W'(NBITS)));
endmodule

// File: rtl/anreg_cmd_master.sv
module anreg_cmd_master
   import anreg_pkg::*;
#(
   parameter int unsigned DIV       = 2,
   parameter int unsigned SEL_W     = 13,
   parameter int unsigned SEL_BASE  = 5,
   parameter int unsigned REG_DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   output logic [31:0]      cmd_rdata,
   output logic [SEL_W-1:0] sel_o,
   output logic             bus_clk_o,
   output logic             bus_dat_o,
   output logic             bus_frame_o
);
   localparam int unsigned BUSY_BIT = CMD_W;

   if (DIV < 2 || SEL_W < SEL_BASE + NUM_SLV || REG_DEPTH < 2 ||
       REG_DEPTH > (1 << ADDR_W) || BUSY_BIT > 31) begin : g_bad_param
      $error("anreg_cmd_master: parameter set out of range");
   end

   cmd_t             cmd_q;
   logic             busy_q, start_q;
   logic [SEL_W-1:0] sel_q, dec_sel;
   logic             dec_hit;
   logic             accept;
   logic             eng_done, eng_frame, eng_clk, eng_dat;
   logic [DAT_W-1:0] eng_rdata;
   logic [NUM_SLV-1:0] miso_v;
   logic             unused_wdata;

   assign accept       = cmd_we && !busy_q;
   assign unused_wdata = ^cmd_wdata[31:CMD_W] ^ dec_hit;

   anreg_sel_decode #(.SEL_W(SEL_W), .SEL_BASE(SEL_BASE)) u_dec (
      .id_i  (cmd_wdata[ID_W-1:0]),
      .sel_o (dec_sel),
      .hit_o (dec_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         sel_q   <= '0;
      end else begin
         start_q <= accept;
         if (accept) begin
            cmd_q  <= cmd_t'(cmd_wdata[CMD_W-1:0]);
            busy_q <= 1'b1;
            sel_q  <= dec_sel;
         end else if (eng_done) begin
            busy_q <= 1'b0;
            if (!cmd_q.dir) cmd_q.data <= eng_rdata;
         end
      end
   end

   anreg_shift_engine #(.DIV(DIV), .ADDR_W(ADDR_W), .DAT_W(DAT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_q),
      .dir_i     (cmd_q.dir),
      .addr_i    (cmd_q.addr),
      .data_i    (cmd_q.data),
      .din_i     (|miso_v),
      .bus_clk_o (eng_clk),
      .bus_dat_o (eng_dat),
      .frame_o   (eng_frame),
      .done_o    (eng_done),
      .rdata_o   (eng_rdata)
   );

   for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
      anreg_model_slave #(.REG_DEPTH(REG_DEPTH), .ADDR_W(ADDR_W), .DAT_W(DAT_W)) u_slv (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_i     (sel_q[SEL_BASE + i]),
         .frame_i   (eng_frame),
         .bus_clk_i (eng_clk),
         .bus_dat_i (eng_dat),
         .miso_o    (miso_v[i])
      );
   end

   always_comb begin
      cmd_rdata = '0;
      cmd_rdata[CMD_W-1:0] = cmd_q;
      cmd_rdata[BUSY_BIT]  = busy_q;
   end

   assign sel_o       = sel_q;
   assign bus_clk_o   = eng_clk;
   assign bus_dat_o   = eng_dat;
   assign bus_frame_o = eng_frame;

   assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q));
   assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !busy_q) |=> busy_q);
   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($stable(cmd_q.id) && $stable(cmd_q.addr) && $stable(cmd_q.dir) && $stable(sel_q)));
   assert_frame_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_frame |-> busy_q);
   assert_unknown_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !cmd_q.dir && sel_q == '0) |=> (cmd_q.data == '0));
endmodule

// File: tb/tb_anreg_cmd_master.sv
`timescale 1ns/1ps
module tb_anreg_cmd_master;
   localparam int DIV = 2;
   localparam int SEL_W = 13;

   logic        clk = 0, rst_n = 0, cmd_we = 0;
   logic [31:0] cmd_wdata = '0, cmd_rdata;
   logic [SEL_W-1:0] sel_o;
   logic        bus_clk_o, bus_dat_o, bus_frame_o;

   anreg_cmd_master #(.DIV(DIV), .SEL_W(SEL_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .sel_o(sel_o), .bus_clk_o(bus_clk_o),
      .bus_dat_o(bus_dat_o), .bus_frame_o(bus_frame_o));

   always #2 clk = ~clk;

   int nchk = 0, nfail = 0;
   logic [7:0] mdl [8][16];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int id_idx(input logic [7:0] id);
      logic [7:0] tab [8] = '{8'h66, 8'h62, 8'h69, 8'h6F, 8'h63, 8'h6D, 8'h67, 8'h6A};
      for (int i = 0; i < 8; i++) if (tab[i] == id) return i;
      return -1;
   endfunction

   function automatic logic [SEL_W-1:0] exp_sel(input logic [7:0] id);
      int k = id_idx(id);
      return (k < 0) ? '0 : (SEL_W'(1) << (5 + k));
   endfunction

   // frame observer
   int cyc = 0, ncap = 0, fr_n = 0, per_bad = 0, last_rise = 0;
   logic [16:0] cap = '0, fr_cap = '0;
   logic pclk = 0, pfr = 0;
   always @(negedge clk) begin
      cyc++;
      if (bus_frame_o && !pfr) ncap = 0;
      if (bus_frame_o && bus_clk_o && !pclk) begin
         cap = {cap[15:0], bus_dat_o};
         if (ncap > 0 && (cyc - last_rise) != 2 * DIV) per_bad++;
         last_rise = cyc;
         ncap++;
      end
      if (!bus_frame_o && pfr) begin fr_cap = cap; fr_n = ncap; end
      pclk = bus_clk_o;
      pfr  = bus_frame_o;
   end

   task automatic wait_idle();
      int n = 0;
      while (cmd_rdata[25] && n < 2000) begin @(negedge clk); n++; end
      chk("R2 busy clears", {31'd0, cmd_rdata[25]}, 32'd0);
   endtask

   // issue one command; optional intruding write while busy
   task automatic do_cmd(input logic [7:0] id, input logic [7:0] addr, input logic dir,
                         input logic [7:0] data, input bit intrude, output logic [7:0] rd);
      int k = id_idx(id);
      logic [7:0] exp_d;
      @(negedge clk);
      cmd_wdata = {7'd0, dir, data, addr, id};
      cmd_we = 1;
      @(negedge clk);
      cmd_we = 0;
      chk("R2 busy rises", {31'd0, cmd_rdata[25]}, 32'd1);
      chk("R4 select", {19'd0, sel_o}, {19'd0, exp_sel(id)});
      if (intrude) begin
         repeat (20) @(negedge clk);
         cmd_wdata = {7'd0, 1'b1, ~data, addr, 8'h67};
         cmd_we = 1;
         @(negedge clk);
         cmd_we = 0;
      end
      wait_idle();
      if (dir) begin
         if (k >= 0) mdl[k][addr[3:0]] = data;
         exp_d = data;
      end else begin
         exp_d = (k >= 0) ? mdl[k][addr[3:0]] : 8'h00;
      end
      chk(intrude ? "R6 fields kept" : "R1 fields", cmd_rdata,
          {6'd0, 1'b0, dir, exp_d, addr, id});
      chk(intrude ? "R6 select kept" : "R5 select", {19'd0, sel_o}, {19'd0, exp_sel(id)});
      chk("R8 frame bits", {fr_cap, 15'd0}, {dir, addr, (dir ? data : fr_cap[7:0]), 15'd0});
      chk("R8 frame length", fr_n, 17);
      rd = cmd_rdata[23:16];
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] tab [8] = '{8'h66, 8'h62, 8'h69, 8'h6F, 8'h63, 8'h6D, 8'h67, 8'h6A};
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) for (int j = 0; j < 16; j++) mdl[i][j] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R9 reset word", cmd_rdata, 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R9 reset select", {19'd0, sel_o}, 32'd0);
      chk("R9 reset frame", {31'd0, bus_frame_o}, 32'd0);

      // R10: registers start at zero
      do_cmd(8'h6A, 8'h0B, 1'b0, 8'h00, 0, rd);
      chk("R10 reset value", rd, 8'h00);
      // R3/R4: every listed slave, write then read
      for (int i = 0; i < 8; i++) do_cmd(tab[i], 8'(i), 1'b1, 8'hA0 + 8'(i), 0, rd);
      for (int i = 0; i < 8; i++) begin
         do_cmd(tab[i], 8'(i), 1'b0, 8'h00, 0, rd);
         chk("R3 readback", rd, 8'hA0 + 8'(i));
      end
      // R10: address alias in low 4 bits
      do_cmd(8'h66, 8'h13, 1'b1, 8'h5A, 0, rd);
      do_cmd(8'h66, 8'h03, 1'b0, 8'hFF, 0, rd);
      chk("R10 alias", rd, 8'h5A);
      // R7: unlisted identifiers
      do_cmd(8'h00, 8'h03, 1'b0, 8'h77, 0, rd);
      chk("R7 unknown read", rd, 8'h00);
      do_cmd(8'h65, 8'h03, 1'b1, 8'hEE, 0, rd);
      chk("R7 unknown select", {19'd0, sel_o}, 32'd0);
      // R6: write while busy ignored
      do_cmd(8'h67, 8'h05, 1'b0, 8'h00, 0, rd);
      do_cmd(8'h6D, 8'h05, 1'b1, 8'h3C, 1, rd);
      do_cmd(8'h67, 8'h05, 1'b0, 8'h00, 0, rd);
      chk("R6 target untouched", rd, mdl[6][5]);
      // random traffic
      for (int n = 0; n < 70; n++) begin
         logic [7:0] id = ($urandom % 4 == 0) ? 8'($urandom) : tab[$urandom % 8];
         logic dir = 1'($urandom);
         do_cmd(id, 8'($urandom), dir, 8'($urandom), 0, rd);
      end
      chk("R8 bit period", per_bad, 0);
      // R9: reset after traffic
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk("R9 reset word again", cmd_rdata, 32'd0);
      chk("R9 reset select again", {19'd0, sel_o}, 32'd0);
      rst_n = 1;
      for (int i = 0; i < 8; i++) for (int j = 0; j < 16; j++) mdl[i][j] = 8'h00;
      do_cmd(8'h66, 8'h03, 1'b0, 8'h00, 0, rd);
      chk("R10 cleared by reset", rd, 8'h00);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule